// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block sits on the outbound path of a local-bus-to-PCI bridge and turns a local-bus address into a PCI bus address. It holds three programmable windows. The two lower-numbered windows describe PCI memory apertures whose size is a power of two from 1 MB to 2 GB. The highest-numbered window is a fixed 16 MB aperture into PCI I/O space. Each window is described by a base register, which says where the window sits on the local bus, and by a map register, which says where it lands on PCI.

The address lookup is purely combinational. Every enabled window compares the incoming address at the same time. The lowest-numbered window that matches supplies the result: the translated address, the PCI cycle-type code, a prefetchable flag, the index of the winning window and a hit flag. Windows may overlap on purpose. For example, software can enlarge window 0 so that it hides window 1 while window 1 is being reprogrammed, then shrink window 0 again to reveal it. The window registers are loaded through a single-cycle write port and reset to the disabled state.

Top module: `addr_window_xlate`

## Requirements
- R1: After a synchronous reset all three windows are disabled, so `xl_hit` stays low for every address until a window is enabled.
- R2: A memory window w is written at select 2w (base) and holds enable in bit 0, base address bits 31:20 in bits 31:20 and a size code k in bits 7:4. It matches when it is enabled, k is 0 to 11 and `lb_addr[31:20+k]` equals the base bits at the same positions, so the window size is 2^(20+k) bytes.
- R3: A memory window whose size code is 12 to 15 never matches, even when it is enabled and the address equals its base.
- R4: On a memory-window hit, `xl_addr[31:20+k]` comes from map bits 15:4 at those positions, which are loaded at select 2w+1. `xl_addr[19+k:2]` equals `lb_addr` at the same positions.
- R5: Map bit 0 set passes `lb_addr[1:0]` through to `xl_addr[1:0]`. Map bit 0 clear forces `xl_addr[1:0]` to 00.
- R6: On a memory-window hit, `xl_ctype` equals map bits 3:1 (0 interrupt ack, 1 I/O, 3 memory, 5 configuration, 6 memory-multiple) and `xl_prefetch` equals base bit 3.
- R7: The I/O window has its base at select 4 (bits 15:8 compared with `lb_addr[31:24]`, bit 0 enable) and its map at select 5 (bits 15:8 become `xl_addr[31:24]`). On a hit `xl_addr[23:0]` equals `lb_addr[23:0]`, `xl_ctype` is 1 and `xl_prefetch` is 0.
- R8: When several enabled windows match, the lowest-numbered one wins. `xl_win` gives its index (memory windows 0 and 1, I/O window 2).
- R9: On a miss, `xl_hit`, `xl_win`, `xl_addr`, `xl_ctype` and `xl_prefetch` are all zero.
- R10: A write takes effect from the clock edge that samples `wr_en`. Selects 6 and 7 change nothing, and a write whose enable bit is clear stops that window from hitting from the next cycle on.
- R11: Base bits 19:8 and 2:1 (this includes the byte-swap field in bits 9:8) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 2w base, 2w+1 map of memory window w; 4 I/O base; 5 I/O map |
| wr_data | input | 32 | Register write data |
| lb_addr | input | 32 | Local-bus address to translate |
| xl_hit | output | 1 | Some enabled window matches |
| xl_win | output | 2 | Index of the winning window |
| xl_addr | output | 32 | Translated PCI address |
| xl_ctype | output | 3 | PCI cycle-type code |
| xl_prefetch | output | 1 | Winning window is prefetchable |

## Verification
The corner cases are these. The first and last byte of a window and the byte just past it: an off-by-one mask would let the next aperture alias in or cut off the top megabyte. The largest legal size code and the illegal codes: a mask built one bit too wide or too narrow would either lose the 2 GB window or let codes 12 to 15 match everything. Two overlap cases, one between the memory windows and one between a memory window and the I/O window: a reversed priority chain would report the later window and hand out its map and cycle type. Finally, unused select values and stray base bits are written, and writes that turn the address low bits on and off are mixed with random reprogramming. A wrong register decode, or a low-bit pass that ignores its control, then shows up as changed or uncleared address bits.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int AW        = 32;  // local and PCI address width
    localparam int MIN_LG    = 20;  // log2 of the smallest memory window
    localparam int HI_W      = AW - MIN_LG;
    localparam int SZ_CODES  = 12;  // legal size codes 0 .. SZ_CODES-1
    localparam int IO_LG     = 24;  // log2 of the fixed I/O window
    localparam int IO_HI_W   = AW - IO_LG;

    typedef enum logic [2:0] {
        CYC_IACK    = 3'd0,
        CYC_IO      = 3'd1,
        CYC_MEM     = 3'd3,
        CYC_CFG     = 3'd5,
        CYC_MEMMULT = 3'd6
    } cyc_e;

    typedef struct packed {
        logic            en;
        logic            pf;
        logic [3:0]      sz;
        logic [HI_W-1:0] base;
    } mem_base_t;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [2:0]      ctype;
        logic            adlow;
    } mem_map_t;

    typedef struct packed {
        logic               en;
        logic [IO_HI_W-1:0] base;
    } io_base_t;

    typedef logic [IO_HI_W-1:0] io_map_t;

    typedef struct packed {
        logic          hit;
        logic [AW-1:0] addr;
        logic [2:0]    ctype;
        logic          pf;
    } xlat_res_t;

    // Ones on the high-address bits a window of size code sz compares.
    function automatic logic [HI_W-1:0] hi_mask(input logic [3:0] sz);
        return {HI_W{1'b1}} << sz;
    endfunction

    function automatic logic size_legal(input logic [3:0] sz);
        return sz < 4'(SZ_CODES);
    endfunction

endpackage

// File: rtl/xlat_win_regs.sv
module xlat_win_regs
    import xlat_pkg::*;
#(
    parameter int N_MEM_WIN = 2,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [AW-1:0]    wr_data,
    output mem_base_t        mem_base [N_MEM_WIN],
    output mem_map_t         mem_map  [N_MEM_WIN],
    output io_base_t         io_base,
    output io_map_t          io_map
);

    localparam int IO_BASE_SEL = 2 * N_MEM_WIN;
    localparam int IO_MAP_SEL  = 2 * N_MEM_WIN + 1;

    // Bits no register field takes.
    logic unused_wr_mid;
    assign unused_wr_mid = ^wr_data[MIN_LG-1:16];

    for (genvar w = 0; w < N_MEM_WIN; w++) begin : g_mem
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_base[w] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(2 * w)) begin
                mem_base[w] <= '{en:   wr_data[0],
                                 pf:   wr_data[3],
                                 sz:   wr_data[7:4],
                                 base: wr_data[AW-1:MIN_LG]};
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                mem_map[w] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(2 * w + 1)) begin
                mem_map[w] <= '{hi:    wr_data[15:4],
                                ctype: wr_data[3:1],
                                adlow: wr_data[0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_base <= '0;
            io_map  <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_W'(IO_BASE_SEL)) begin
                io_base <= '{en: wr_data[0], base: wr_data[15:8]};
            end
            if (wr_sel == SEL_W'(IO_MAP_SEL)) begin
                io_map <= wr_data[15:8];
            end
        end
    end

endmodule

// File: rtl/xlat_mem_win.sv
module xlat_mem_win
    import xlat_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  mem_base_t     base,
    input  mem_map_t      map,
    output xlat_res_t     res
);

    logic [HI_W-1:0] mask;
    logic [HI_W-1:0] addr_hi;
    logic            match;
    logic [HI_W-1:0] new_hi;

    assign addr_hi = addr[AW-1:MIN_LG];
    assign mask    = hi_mask(base.sz);
    assign match   = base.en && size_legal(base.sz)
                     && (((addr_hi ^ base.base) & mask) == '0);
    assign new_hi  = (map.hi & mask) | (addr_hi & ~mask);

    always_comb begin
        res = '0;
        if (match) begin
            res.hit   = 1'b1;
            res.addr  = {new_hi, addr[MIN_LG-1:2],
                         (map.adlow ? addr[1:0] : 2'b00)};
            res.ctype = map.ctype;
            res.pf    = base.pf;
        end
    end

endmodule

// File: rtl/xlat_io_win.sv
module xlat_io_win
    import xlat_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  io_base_t      base,
    input  io_map_t       map,
    output xlat_res_t     res
);

    logic match;
    assign match = base.en && (addr[AW-1:IO_LG] == base.base);

    always_comb begin
        res = '0;
        if (match) begin
            res.hit   = 1'b1;
            res.addr  = {map, addr[IO_LG-1:0]};
            res.ctype = CYC_IO;
            res.pf    = 1'b0;
        end
    end

endmodule

// File: rtl/xlat_prio_sel.sv
module xlat_prio_sel
    import xlat_pkg::*;
#(
    parameter int NW    = 3,
    parameter int IDX_W = 2
) (
    input  xlat_res_t        cand [NW],
    output xlat_res_t        win_res,
    output logic [IDX_W-1:0] win_idx
);

    // Scan from the top down so the lowest matching index is written last.
    always_comb begin
        win_res = '0;
        win_idx = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (cand[i].hit) begin
                win_res = cand[i];
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import xlat_pkg::*;
#(
    parameter  int N_MEM_WIN = 2,
    localparam int SEL_W     = $clog2(2 * N_MEM_WIN + 2),
    localparam int IDX_W     = $clog2(N_MEM_WIN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [31:0]      lb_addr,
    output logic             xl_hit,
    output logic [IDX_W-1:0] xl_win,
    output logic [31:0]      xl_addr,
    output logic [2:0]       xl_ctype,
    output logic             xl_prefetch
);

    localparam int NW = N_MEM_WIN + 1;

    mem_base_t mem_base [N_MEM_WIN];
    mem_map_t  mem_map  [N_MEM_WIN];
    io_base_t  io_base;
    io_map_t   io_map;
    xlat_res_t cand     [NW];
    xlat_res_t win_res;

    xlat_win_regs #(
        .N_MEM_WIN (N_MEM_WIN),
        .SEL_W     (SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .mem_base (mem_base),
        .mem_map  (mem_map),
        .io_base  (io_base),
        .io_map   (io_map)
    );

    for (genvar w = 0; w < N_MEM_WIN; w++) begin : g_mwin
        xlat_mem_win u_mwin (
            .addr (lb_addr),
            .base (mem_base[w]),
            .map  (mem_map[w]),
            .res  (cand[w])
        );
    end

    xlat_io_win u_iowin (
        .addr (lb_addr),
        .base (io_base),
        .map  (io_map),
        .res  (cand[N_MEM_WIN])
    );

    xlat_prio_sel #(
        .NW    (NW),
        .IDX_W (IDX_W)
    ) u_prio (
        .cand    (cand),
        .win_res (win_res),
        .win_idx (xl_win)
    );

    assign xl_hit      = win_res.hit;
    assign xl_addr     = win_res.addr;
    assign xl_ctype    = win_res.ctype;
    assign xl_prefetch = win_res.pf;

endmodule

// File: rtl/addr_window_xlate_chk.sv
module addr_window_xlate_chk #(
    parameter int N_MEM_WIN = 2,
    parameter int SEL_W     = 3,
    parameter int IDX_W     = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [31:0]      wr_data,
    input logic [31:0]      lb_addr,
    input logic             xl_hit,
    input logic [IDX_W-1:0] xl_win,
    input logic [31:0]      xl_addr,
    input logic [2:0]       xl_ctype,
    input logic             xl_prefetch
);

    localparam logic [IDX_W-1:0] IO_IDX = IDX_W'(N_MEM_WIN);

    AST_RESET_CLEARS_HIT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !xl_hit);  // R1

    AST_MISS_ALL_ZERO: assert property (@(posedge clk) disable iff (rst)
        !xl_hit |-> (xl_addr == '0 && xl_ctype == '0 && !xl_prefetch && xl_win == '0));  // R9

    AST_MEM_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (xl_hit && xl_win < IO_IDX) |-> (xl_addr[19:2] == lb_addr[19:2]));  // R4

    AST_ADLOW_PASS_OR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (xl_hit && xl_win < IO_IDX && xl_addr[1:0] != lb_addr[1:0]) |-> (xl_addr[1:0] == 2'b00));  // R5

    AST_IO_WINDOW_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (xl_hit && xl_win == IO_IDX) |-> (xl_ctype == 3'd1 && !xl_prefetch && xl_addr[23:0] == lb_addr[23:0]));  // R7

    AST_WIN_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
        xl_hit |-> (xl_win <= IO_IDX));  // R8

    AST_IO_DISABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_W'(2 * N_MEM_WIN) && !wr_data[0]) |=> !(xl_hit && xl_win == IO_IDX));  // R10

endmodule

bind addr_window_xlate addr_window_xlate_chk #(
    .N_MEM_WIN (N_MEM_WIN),
    .SEL_W     (SEL_W),
    .IDX_W     (IDX_W)
) u_chk (.*);

// File: tb/sim_addr_window_xlate.sv
`timescale 1ns/1ps
module sim_addr_window_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic [31:0] lb_addr;
    logic        xl_hit;
    logic [1:0]  xl_win;
    logic [31:0] xl_addr;
    logic [2:0]  xl_ctype;
    logic        xl_prefetch;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench copy of what has been written, kept from the requirements.
    logic [31:0] m_base [2];
    logic [15:0] m_map  [2];
    logic [15:0] m_iob;
    logic [15:0] m_iom;

    always #2.5 clk = ~clk;

    addr_window_xlate u0 (
        .clk, .rst, .wr_en, .wr_sel, .wr_data, .lb_addr,
        .xl_hit, .xl_win, .xl_addr, .xl_ctype, .xl_prefetch
    );

    task automatic model_clear();
        for (int w = 0; w < 2; w++) begin
            m_base[w] = '0;
            m_map[w]  = '0;
        end
        m_iob = '0;
        m_iom = '0;
    endtask

    task automatic model(input logic [31:0] a, output logic eh, output logic [1:0] ew,
                         output logic [31:0] ea, output logic [2:0] ec, output logic ep);
        eh = 0; ew = 0; ea = 0; ec = 0; ep = 0;
        for (int w = 1; w >= 0; w--) begin
            int lg;
            logic [31:0] keep;
            lg = 20 + int'(m_base[w][7:4]);
            if (m_base[w][0] && m_base[w][7:4] <= 4'd11 && (a >> lg) == (m_base[w] >> lg)) begin
                keep = 32'hFFFF_FFFF << lg;
                eh = 1;
                ew = 2'(w);
                ea = ({m_map[w][15:4], 20'h0} & keep) | (a & ~keep);
                if (!m_map[w][0]) ea[1:0] = 2'b00;
                ec = m_map[w][3:1];
                ep = m_base[w][3];
            end
        end
        if (!eh && m_iob[0] && a[31:24] == m_iob[15:8]) begin
            eh = 1; ew = 2; ea = {m_iom[15:8], a[23:0]}; ec = 3'd1; ep = 0;
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 0;
        case (sel)
            3'd0: m_base[0] = data;
            3'd1: m_map[0]  = data[15:0];
            3'd2: m_base[1] = data;
            3'd3: m_map[1]  = data[15:0];
            3'd4: m_iob     = data[15:0];
            3'd5: m_iom     = data[15:0];
            default: ;
        endcase
    endtask

    task automatic chk(input logic [31:0] a, input string req);
        logic eh; logic [1:0] ew; logic [31:0] ea; logic [2:0] ec; logic ep;
        lb_addr = a;
        #1;
        model(a, eh, ew, ea, ec, ep);
        checks++;
        if ({xl_hit, xl_win, xl_addr, xl_ctype, xl_prefetch} !== {eh, ew, ea, ec, ep}) begin
            errors++;
            $display("FAIL %s addr=%h actual hit=%0b win=%0d pa=%h ct=%0d pf=%0b expected hit=%0b win=%0d pa=%h ct=%0d pf=%0b",
                     req, a, xl_hit, xl_win, xl_addr, xl_ctype, xl_prefetch, eh, ew, ea, ec, ep);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        model_clear();
        rst = 1; wr_en = 0; wr_sel = 0; wr_data = 0; lb_addr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: nothing hits after reset
        chk(32'h0000_0000, "R1");
        chk(32'h4000_0000, "R1");
        chk(32'hFFFF_FFFF, "R1");

        // R2 R4 R5: window 0, 256 MB at 0x4000_0000 -> PCI 0x8000_0000, memory, low bits forced
        wr(3'd0, 32'h4000_0081);
        wr(3'd1, 32'h0000_8006);
        chk(32'h4123_4567, "R4");
        chk(32'h4000_0000, "R2");
        chk(32'h4FFF_FFFF, "R2");
        chk(32'h5000_0000, "R2");
        chk(32'h3FFF_FFFF, "R2");

        // R5 R6: window 1 prefetchable, memory-multiple, low bits passed
        wr(3'd2, 32'h5000_0089);
        wr(3'd3, 32'h0000_900D);
        chk(32'h5000_0003, "R5");
        chk(32'h5ABC_DEF2, "R6");

        // R8: window 0 grown to 512 MB hides window 1
        wr(3'd0, 32'h4000_0091);
        chk(32'h5000_0003, "R8");
        chk(32'h5FFF_FFFE, "R8");

        // R6: window 1 re-aimed at configuration space, 16 MB
        wr(3'd2, 32'h6100_0041);
        wr(3'd3, 32'h0000_000B);
        chk(32'h6100_0A07, "R6");
        chk(32'h6200_0000, "R6");

        // R7: I/O window 0x60xx_xxxx -> 0x00xx_xxxx
        wr(3'd4, 32'h0000_6001);
        wr(3'd5, 32'h0000_0000);
        chk(32'h6012_3457, "R7");
        chk(32'h60FF_FFFF, "R7");
        // R8: memory window over the I/O window wins
        wr(3'd2, 32'h6000_0051);
        chk(32'h6012_3457, "R8");

        // R3: illegal size codes never match
        wr(3'd2, 32'h6000_00C1);
        chk(32'h6000_0000, "R3");
        wr(3'd2, 32'h6000_00F1);
        chk(32'h6000_0010, "R3");
        // R2: largest legal size, 2 GB
        wr(3'd2, 32'h8000_00B1);
        wr(3'd3, 32'h0000_1007);
        chk(32'hFFFF_FFFF, "R2");
        chk(32'h8000_0000, "R2");
        chk(32'h7FFF_FFFF, "R2");

        // R10: selects 6 and 7 change nothing
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'h0000_0000);
        chk(32'h4123_4567, "R10");
        chk(32'h6012_3457, "R10");
        chk(32'hC000_0001, "R10");

        // R11: swap field and spare base bits are ignored
        wr(3'd0, 32'h400F_FF87);
        chk(32'h4123_4567, "R11");
        chk(32'h5000_0000, "R11");

        // R10: clearing enable stops hits
        wr(3'd4, 32'h0000_6000);
        chk(32'h6012_3457, "R10");
        wr(3'd0, 32'h4000_0080);
        chk(32'h4123_4567, "R10");

        // R4 R5 R6 R8: random reprogramming and addresses
        for (int it = 0; it < 400; it++) begin
            if ($urandom % 3 == 0) begin
                logic [31:0] d;
                logic [2:0]  s;
                s = 3'($urandom % 8);
                d = $urandom;
                if (s == 3'd0 || s == 3'd2) d[7:4] = 4'($urandom % 14);
                if ($urandom % 4 != 0) d[0] = 1'b1;
                wr(s, d);
            end
            begin
                logic [31:0] a;
                int w;
                a = $urandom;
                w = int'($urandom % 3);
                if (w < 2) begin
                    if ($urandom % 4 != 0) a[31:28] = m_base[w][31:28];
                end else begin
                    if ($urandom % 2 == 0) a[31:24] = m_iob[15:8];
                end
                chk(a, "R4");
            end
        end

        // R1: reset in the middle of operation clears every window
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        model_clear();
        chk(32'h6012_3457, "R1");
        chk(32'hFFFF_FFFF, "R1");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule